// File: doc/BRIEF.md
# Packet FIFO interrupt and reset-key controller

This block sits beside the transmit and receive data paths of a memory-mapped packet FIFO. It collects single-cycle event pulses from those paths and holds them in a 32-bit status word. Software clears bits by writing ones to them. A matching enable word masks the events, and one level interrupt output is raised whenever an enabled status bit is set.

The same register port carries three reset registers: one for the transmit side, one for the receive side and one for the whole core. A reset acts only when software writes the exact key value 0x000000A5. A valid key write produces a one-cycle reset pulse toward the affected data paths. It also sets a reset-complete status bit for each path that was reset. The register port is a plain 32-bit write/read port with a word address. A write takes effect on the clock edge where `reg_wr_en` is high. Read data is a combinational function of `reg_addr` and the current register state. There is no streaming interface, so no back-pressure applies.

Top module: `irq_reset_ctrl`

## Requirements
- R1: While and after reset, the status word, the enable word, `irq` and all three reset pulses are zero.
- R2: A pulse on `evt_pulse[k]` sets status bit 19+k at the next edge, and the bit stays set until cleared. The index map is: k=12 receive under-read (bit 31), 11 receive over-read, 10 receive underrun, 9 transmit overrun, 8 transmit done, 7 receive done, 6 transmit length mismatch, 5 transmit reset done (bit 24), 4 receive reset done (bit 23), 3 transmit almost-full, 2 transmit almost-empty, 1 receive almost-full, 0 receive almost-empty (bit 19).
- R3: A write to word address 0 (status) clears each status bit written as one and leaves bits written as zero unchanged. Writing 0xFFF80000 clears every bit.
- R4: If an event and a clear hit the same status bit in the same cycle, the bit ends set.
- R5: Word address 1 is the enable word. Bits 31..19 of the enable word can be written and read. Bits 18..0 of both the status and enable words read as zero, and writes to them are ignored.
- R6: `irq` is high exactly while the bitwise AND of status and enable is nonzero.
- R7: Writing 0x000000A5 to word address 2 makes `tx_path_rst` high in the following cycle and sets status bit 24.
- R8: Writing 0x000000A5 to word address 6 makes `rx_path_rst` high in the following cycle and sets status bit 23.
- R9: Writing 0x000000A5 to word address 10 makes `core_rst`, `tx_path_rst` and `rx_path_rst` all high in the following cycle, and sets both bits 24 and 23.
- R10: Any other value written to the three reset addresses produces no pulse and leaves the status word unchanged.
- R11: Reads of any address other than 0 and 1, including the reset addresses, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Word address for reads and writes |
| reg_wr_en | input | 1 | Write strobe, one write per cycle |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Read data for `reg_addr`, combinational |
| evt_pulse | input | 13 | Event pulses; index k maps to status bit 19+k |
| irq | output | 1 | Level interrupt |
| tx_path_rst | output | 1 | One-cycle reset pulse to the transmit path |
| rx_path_rst | output | 1 | One-cycle reset pulse to the receive path |
| core_rst | output | 1 | One-cycle whole-core reset pulse |

## Verification
The assertions check four properties on every cycle. Each event pulse lands in the status word. Every reset pulse is accompanied by its done bit. A core reset always drives both path resets. A non-key write to a reset address never produces a pulse. The low status bits are checked to read zero at all times. Other properties depend on what software did earlier, so only the bench scenarios can show them. These are the exact clear-by-ones arithmetic, an event winning over a clear, the interrupt following the enable mask, and the reset-time values. The bench tracks them with a cycle-accurate model under both directed and random register traffic.

// File: rtl/ikc_pkg.sv
package ikc_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned EVT_N   = 13;
  localparam int unsigned EVT_LSB = WORD_W - EVT_N;

  // event indices of the reset-done bits (status bits 24 and 23)
  localparam int unsigned EVT_TX_DONE = 5;
  localparam int unsigned EVT_RX_DONE = 4;

  // word addresses
  localparam int unsigned ADR_STATUS   = 0;
  localparam int unsigned ADR_ENABLE   = 1;
  localparam int unsigned ADR_TX_RST   = 2;
  localparam int unsigned ADR_RX_RST   = 6;
  localparam int unsigned ADR_CORE_RST = 10;

  typedef struct packed {
    logic status_wr;
    logic enable_wr;
    logic tx_kick;
    logic rx_kick;
    logic core_kick;
  } strobe_t;
endpackage

// File: rtl/ikc_decode.sv
module ikc_decode
  import ikc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter logic [WORD_W-1:0] KEY = 32'h0000_00A5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output strobe_t           strb
);
  logic key_ok;
  assign key_ok = (wr_data == KEY);

  always_comb begin
    strb           = '0;
    strb.status_wr = wr_en && (addr == ADDR_W'(ADR_STATUS));
    strb.enable_wr = wr_en && (addr == ADDR_W'(ADR_ENABLE));
    strb.tx_kick   = wr_en && key_ok && (addr == ADDR_W'(ADR_TX_RST));
    strb.rx_kick   = wr_en && key_ok && (addr == ADDR_W'(ADR_RX_RST));
    strb.core_kick = wr_en && key_ok && (addr == ADDR_W'(ADR_CORE_RST));
  end
endmodule

// File: rtl/ikc_reset_gen.sv
module ikc_reset_gen
  import ikc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t strb,
  output logic    tx_done_set,
  output logic    rx_done_set,
  output logic    tx_rst,
  output logic    rx_rst,
  output logic    core_rst
);
  logic tx_any, rx_any;
  assign tx_any      = strb.tx_kick | strb.core_kick;
  assign rx_any      = strb.rx_kick | strb.core_kick;
  assign tx_done_set = tx_any;
  assign rx_done_set = rx_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_rst   <= 1'b0;
      rx_rst   <= 1'b0;
      core_rst <= 1'b0;
    end else begin
      tx_rst   <= tx_any;
      rx_rst   <= rx_any;
      core_rst <= strb.core_kick;
    end
  end
endmodule

// File: rtl/ikc_status.sv
module ikc_status #(
  parameter int unsigned N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic         en_wr,
  input  logic [N-1:0] en_data,
  output logic [N-1:0] stat,
  output logic [N-1:0] en,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) stat[i] <= 1'b0;
      else        stat[i] <= set_vec[i] | (stat[i] & ~clr_vec[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     en <= '0;
    else if (en_wr) en <= en_data;
  end

  assign irq = |(stat & en);
endmodule

// File: rtl/irq_reset_ctrl.sv
module irq_reset_ctrl
  import ikc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter logic [31:0] KEY = 32'h0000_00A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [31:0]       reg_wr_data,
  output logic [31:0]       reg_rd_data,
  input  logic [12:0]       evt_pulse,
  output logic              irq,
  output logic              tx_path_rst,
  output logic              rx_path_rst,
  output logic              core_rst
);
  strobe_t          strb;
  logic             tx_done_set, rx_done_set;
  logic [EVT_N-1:0] set_vec, clr_vec, stat_w, en_w;

  ikc_decode #(.ADDR_W(ADDR_W), .KEY(KEY)) u_dec (
    .addr(reg_addr), .wr_en(reg_wr_en), .wr_data(reg_wr_data), .strb(strb)
  );

  ikc_reset_gen u_rst (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .tx_done_set(tx_done_set), .rx_done_set(rx_done_set),
    .tx_rst(tx_path_rst), .rx_rst(rx_path_rst), .core_rst(core_rst)
  );

  always_comb begin
    set_vec              = evt_pulse;
    set_vec[EVT_TX_DONE] = evt_pulse[EVT_TX_DONE] | tx_done_set;
    set_vec[EVT_RX_DONE] = evt_pulse[EVT_RX_DONE] | rx_done_set;
  end

  assign clr_vec = strb.status_wr ? reg_wr_data[WORD_W-1:EVT_LSB] : '0;

  ikc_status #(.N(EVT_N)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .en_wr(strb.enable_wr), .en_data(reg_wr_data[WORD_W-1:EVT_LSB]),
    .stat(stat_w), .en(en_w), .irq(irq)
  );

  always_comb begin
    reg_rd_data = '0;
    if (reg_addr == ADDR_W'(ADR_STATUS))      reg_rd_data = {stat_w, {EVT_LSB{1'b0}}};
    else if (reg_addr == ADDR_W'(ADR_ENABLE)) reg_rd_data = {en_w, {EVT_LSB{1'b0}}};
  end
endmodule

// File: rtl/ikc_checker.sv
module ikc_checker
  import ikc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter logic [31:0] KEY = 32'h0000_00A5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr_en,
  input logic [31:0]       reg_wr_data,
  input logic [31:0]       reg_rd_data,
  input logic [EVT_N-1:0]  evt_pulse,
  input logic [EVT_N-1:0]  status_q,
  input logic              tx_path_rst,
  input logic              rx_path_rst,
  input logic              core_rst
);
  // R2
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((status_q & $past(evt_pulse)) == $past(evt_pulse)));

  // R5
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[EVT_LSB-1:0] == '0);

  // R7
  tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_path_rst |-> status_q[EVT_TX_DONE]);

  // R8
  rx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_path_rst |-> status_q[EVT_RX_DONE]);

  // R9
  core_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (tx_path_rst && rx_path_rst));

  // R10
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_data != KEY &&
     (reg_addr == ADDR_W'(ADR_TX_RST) || reg_addr == ADDR_W'(ADR_RX_RST) ||
      reg_addr == ADDR_W'(ADR_CORE_RST)))
    |=> (!tx_path_rst && !rx_path_rst && !core_rst));
endmodule

bind irq_reset_ctrl ikc_checker #(.ADDR_W(ADDR_W), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
  .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .evt_pulse(evt_pulse),
  .status_q(stat_w), .tx_path_rst(tx_path_rst), .rx_path_rst(rx_path_rst),
  .core_rst(core_rst)
);

// File: tb/test_irq_reset_ctrl.sv
module test_irq_reset_ctrl;
  localparam logic [31:0] KEY = 32'h0000_00A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic [12:0] evt_pulse = '0;
  logic        irq, tx_path_rst, rx_path_rst, core_rst;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [12:0] m_st = '0;
  logic [12:0] m_en = '0;

  always #5 clk = ~clk;

  irq_reset_ctrl #(.ADDR_W(4), .KEY(KEY)) i_irq_reset_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .evt_pulse(evt_pulse),
    .irq(irq), .tx_path_rst(tx_path_rst), .rx_path_rst(rx_path_rst),
    .core_rst(core_rst)
  );

  function automatic logic [31:0] model_rd(input logic [3:0] a);
    if (a == 4'd0) return {m_st, 19'd0};
    if (a == 4'd1) return {m_en, 19'd0};
    return 32'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] a, input logic we, input logic [31:0] d,
                      input logic [12:0] ev, input string tag);
    logic ktx, krx, kc;
    logic [12:0] setv, clrv;
    string rtag;
    @(negedge clk);
    reg_addr = a; reg_wr_en = we; reg_wr_data = d; evt_pulse = ev;
    ktx  = we && a == 4'd2  && d == KEY;
    krx  = we && a == 4'd6  && d == KEY;
    kc   = we && a == 4'd10 && d == KEY;
    clrv = (we && a == 4'd0) ? d[31:19] : 13'd0;
    setv = ev;
    if (ktx || kc) setv[5] = 1'b1;
    if (krx || kc) setv[4] = 1'b1;
    m_st = setv | (m_st & ~clrv);
    if (we && a == 4'd1) m_en = d[31:19];
    @(posedge clk);
    #2;
    rtag = (a == 4'd0) ? "R2" : (a == 4'd1) ? "R5" : "R11";
    check(tag == "" ? "R6" : tag, {31'd0, irq}, {31'd0, |(m_st & m_en)});
    check(tag == "" ? "R7" : tag, {31'd0, tx_path_rst}, {31'd0, ktx || kc});
    check(tag == "" ? "R8" : tag, {31'd0, rx_path_rst}, {31'd0, krx || kc});
    check(tag == "" ? "R9" : tag, {31'd0, core_rst}, {31'd0, kc});
    check(tag == "" ? rtag : tag, reg_rd_data, model_rd(a));
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset values
    repeat (3) @(posedge clk);
    @(negedge clk);
    reg_addr = 4'd0;
    #1;
    check("R1", reg_rd_data, 32'd0);
    check("R1", {28'd0, irq, tx_path_rst, rx_path_rst, core_rst}, 32'd0);
    reg_addr = 4'd1;
    #1;
    check("R1", reg_rd_data, 32'd0);
    rst_n = 1'b1;

    // R2: each event alone
    for (int k = 0; k < 13; k++) step(4'd0, 1'b0, 32'd0, 13'(1 << k), "R2");
    // R3: partial clear, then full clear
    step(4'd0, 1'b1, 32'hAAA8_0000, 13'd0, "R3");
    step(4'd0, 1'b1, 32'hFFF8_0000, 13'd0, "R3");
    // R4: event and clear collide on bit 26
    step(4'd0, 1'b0, 32'd0, 13'h0080, "R4");
    step(4'd0, 1'b1, 32'h0400_0000, 13'h0080, "R4");
    step(4'd0, 1'b1, 32'hFFF8_0000, 13'd0, "R3");
    // R5: enable width, low bits ignored
    step(4'd1, 1'b1, 32'hFFFF_FFFF, 13'd0, "R5");
    step(4'd0, 1'b1, 32'h0007_FFFF, 13'd0, "R5");
    // R6: interrupt follows the mask
    step(4'd1, 1'b1, 32'h8000_0000, 13'd0, "R6");
    step(4'd0, 1'b0, 32'd0, 13'h0800, "R6");
    step(4'd0, 1'b0, 32'd0, 13'h1000, "R6");
    step(4'd0, 1'b1, 32'h8000_0000, 13'd0, "R6");
    step(4'd0, 1'b1, 32'hFFF8_0000, 13'd0, "R6");
    // R7, R8, R9: key writes
    step(4'd2, 1'b1, KEY, 13'd0, "R7");
    step(4'd0, 1'b0, 32'd0, 13'd0, "R7");
    step(4'd0, 1'b1, 32'hFFF8_0000, 13'd0, "R3");
    step(4'd6, 1'b1, KEY, 13'd0, "R8");
    step(4'd0, 1'b0, 32'd0, 13'd0, "R8");
    step(4'd10, 1'b1, KEY, 13'd0, "R9");
    step(4'd0, 1'b0, 32'd0, 13'd0, "R9");
    step(4'd0, 1'b1, 32'hFFF8_0000, 13'd0, "R3");
    // R10: near-miss keys
    step(4'd2, 1'b1, 32'h0000_00A4, 13'd0, "R10");
    step(4'd6, 1'b1, 32'h0000_01A5, 13'd0, "R10");
    step(4'd10, 1'b1, 32'hA500_0000, 13'd0, "R10");
    step(4'd0, 1'b0, 32'd0, 13'd0, "R10");
    // R11: other addresses read zero
    for (int a = 2; a < 16; a++) step(4'(a), 1'b0, 32'd0, 13'h1FFF, "R11");

    // random traffic
    for (int n = 0; n < 500; n++) begin
      logic [3:0]  ra;
      logic        rw;
      logic [31:0] rd;
      logic [12:0] re;
      case ($urandom_range(0, 5))
        0: ra = 4'd2;
        1: ra = 4'd6;
        2: ra = 4'd10;
        3: ra = 4'd1;
        4: ra = 4'd0;
        default: ra = 4'($urandom_range(0, 15));
      endcase
      rw = ($urandom_range(0, 2) != 0);
      rd = ($urandom_range(0, 3) == 0) ? KEY : $urandom;
      re = ($urandom_range(0, 3) == 0) ? 13'($urandom) : 13'd0;
      step(ra, rw, rd, re, "");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule